// File: doc/BRIEF.md
# Subrate Bit Extract/Inject Switch

This block sits on one serial TDM stream of 128 eight-bit time slots per 125 µs frame (8 Mbit/s, one bit per clock). For every slot, a per-slot control word chooses one of four treatments. The slot can pass through untouched. One or two of its bits can be copied out to the host. One or two of its bits can be overwritten with bits the host supplied. Or both can happen in the same slot: the original bits are copied out and the new bits are written in. Bit width and bit position are chosen separately for each slot, so a 16 kbit/s subchannel can be carried at any position in any slot.

Copied-out bits are packed into bytes and queued for the host, which reads them as a continuous bit stream, for example for a software HDLC/LAPD receiver. Bits to be written in are taken one after another from a byte queue that the host fills. Every output bit appears exactly one slot time (8 clocks) after it entered. This delay gives the block the whole slot byte before it must start sending that byte.

Top module: `subrate_xi_switch`

## Requirements
- R1: A slot with mode 00 (pass) leaves the block unchanged. Every output bit appears on `ser_out` exactly 8 clocks after it was sampled on `ser_in`. Out of reset, `ser_out` is 0 until the first processed byte comes out.
- R2: The control word is `cfg_word[5:4]` = mode (00 pass, 01 extract, 10 inject, 11 both), `cfg_word[3]` = width (0: one bit, 1: two bits) and `cfg_word[2:0]` = start position p, where bit 7 is the first bit on the wire. A one-bit extract copies bit p of the slot into the extract queue. Extracted bits are packed MSB first into bytes, and a byte becomes readable in the cycle after its eighth bit completes.
- R3: A two-bit extract copies bit p+1 first and then bit p.
- R4: An inject replaces only the selected positions with the next bits of the inject stream. The stream is made of the queued bytes, each read MSB first. For width 2, bit p+1 receives the earlier bit. All other bits of the slot pass through unchanged.
- R5: Mode 11 extracts the original bits at the selected positions and injects new bits into those same positions.
- R6: Width 2 with start position 7 is invalid. Such a slot passes through unchanged, and nothing is extracted or consumed.
- R7: A high `frame_sync` marks the cycle that carries bit 7 of slot 0. It realigns the slot count at any time, even in the middle of a frame.
- R8: The extract queue holds 16 bytes. A completed byte that arrives while the queue is full is dropped and sets `ext_ovf`, which stays set until reset. `ext_valid` shows a non-empty queue, and `ext_data` shows its oldest byte.
- R9: If injection needs bits and no queued bits remain, ones are inserted in their place and `inj_udr` is set. It stays set until reset.
- R10: `inj_full` is high when 16 bytes are queued for injection. A host write in a cycle that starts full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the cycle carrying slot 0 bit 7 |
| ser_in | input | 1 | Serial input stream, MSB first |
| ser_out | output | 1 | Serial output stream, delayed by 8 clocks |
| cfg_we | input | 1 | Write strobe for the per-slot control memory |
| cfg_slot | input | 7 | Slot index to write |
| cfg_word | input | 6 | Control word {mode[1:0], width, start[2:0]} |
| ext_rd | input | 1 | Pop the oldest extracted byte |
| ext_data | output | 8 | Oldest extracted byte |
| ext_valid | output | 1 | Extract queue not empty |
| ext_ovf | output | 1 | Sticky extract overflow |
| inj_we | input | 1 | Push a byte for injection |
| inj_data | input | 8 | Byte to inject, MSB used first |
| inj_full | output | 1 | Inject queue full |
| inj_udr | output | 1 | Sticky inject underrun |

## Verification
The processed byte of a slot is loaded at the clock edge that ends the slot's last bit. Its first bit therefore leaves on `ser_out` 8 cycles after the slot's first bit went in. The bench writes the expected bits for those eight future cycles into a table and compares against the table one bit per cycle. The queue outputs and the two sticky flags change at the edge that ends the cycle of the triggering slot, host read or host write. For that reason the bench updates its reference queues after it drives each cycle and compares them in the next cycle. All samples are taken on the falling edge, halfway between the edges that change the design.

// File: rtl/subrate_pkg.sv
package subrate_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'b00,
    MODE_EXT  = 2'b01,
    MODE_INJ  = 2'b10,
    MODE_BOTH = 2'b11
  } sub_mode_e;

  typedef struct packed {
    sub_mode_e  mode;
    logic       wide;
    logic [2:0] start;
  } slot_cfg_t;

  typedef struct packed {
    logic [7:0] acc;
    logic [3:0] cnt;
    logic       done;
    logic [7:0] data;
  } pack_t;

  // two-bit field starting at 7 would run off the byte
  function automatic logic cfg_ok(slot_cfg_t c);
    return !(c.wide && (c.start == 3'd7));
  endfunction

  function automatic logic [7:0] field_mask(slot_cfg_t c);
    return c.wide ? (8'b0000_0011 << c.start) : (8'b0000_0001 << c.start);
  endfunction

  // {earlier, later}; single bit returned in [0]
  function automatic logic [1:0] field_get(logic [7:0] b, slot_cfg_t c);
    logic [7:0] sh;
    sh = b >> c.start;
    return c.wide ? sh[1:0] : {1'b0, sh[0]};
  endfunction

  function automatic logic [7:0] field_put(logic [7:0] b, slot_cfg_t c, logic [1:0] v);
    logic [7:0] m;
    logic [7:0] ins;
    m   = field_mask(c);
    ins = {6'b0, (c.wide ? v : {1'b0, v[0]})} << c.start;
    return (b & ~m) | (ins & m);
  endfunction

  // append 1 or 2 bits to a right-aligned accumulator of cnt bits
  function automatic pack_t pack_step(logic [7:0] acc, logic [3:0] cnt,
                                      logic [1:0] bits, logic two);
    pack_t      r;
    logic [9:0] t;
    logic [3:0] nc;
    t  = two ? {acc, bits} : {1'b0, acc, bits[0]};
    nc = cnt + (two ? 4'd2 : 4'd1);
    r  = '0;
    if (nc >= 4'd8) begin
      r.done = 1'b1;
      r.cnt  = nc - 4'd8;
      r.data = 8'(t >> r.cnt);
      r.acc  = 8'(t & ((10'd1 << r.cnt) - 10'd1));
    end else begin
      r.acc = t[7:0];
      r.cnt = nc;
    end
    return r;
  endfunction

endpackage

// File: rtl/subrate_fifo.sv
module subrate_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  // R8 R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH));

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/subrate_cmem.sv
module subrate_cmem #(
  parameter int SLOTS = 128,
  parameter int CW    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(SLOTS)-1:0] waddr,
  input  logic [CW-1:0]            wdata,
  input  logic [$clog2(SLOTS)-1:0] raddr,
  output logic [CW-1:0]            rdata
);
  logic [CW-1:0] mem [SLOTS];

  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/subrate_timing.sv
module subrate_timing #(
  parameter int SLOTS = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  output logic [$clog2(SLOTS)-1:0] slot_idx,
  output logic                     slot_end
);
  localparam int FRAME_BITS = SLOTS * 8;
  localparam int PW         = $clog2(FRAME_BITS);

  logic [PW-1:0] pos_q, cur_pos;

  always_comb begin
    if (frame_sync)                             cur_pos = '0;
    else if (pos_q == PW'(FRAME_BITS - 1))      cur_pos = '0;
    else                                        cur_pos = pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= PW'(FRAME_BITS - 1);
    else        pos_q <= cur_pos;
  end

  assign slot_idx = cur_pos[PW-1:3];
  assign slot_end = (cur_pos[2:0] == 3'd7);

  // R7
  slot_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !slot_end);

endmodule

// File: rtl/subrate_unpacker.sv
module subrate_unpacker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       two,
  input  logic [7:0] head,
  input  logic       head_valid,
  output logic [1:0] bits,
  output logic       pop,
  output logic       underrun
);
  logic [7:0]  cur;
  logic [3:0]  rem;
  logic [3:0]  need;
  logic        short_bits;
  logic [15:0] have, fill, win, after;

  always_comb begin
    need       = two ? 4'd2 : 4'd1;
    short_bits = (need > rem);
    have       = {cur, 8'h00} & ~(16'hFFFF >> rem);
    fill       = head_valid ? ({head, 8'h00} >> rem) : (16'hFFFF >> rem);
    win        = have | fill;
    after      = win << need;
    bits       = two ? win[15:14] : {1'b0, win[15]};
    pop        = take && short_bits && head_valid;
    underrun   = take && short_bits && !head_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
      rem <= '0;
    end else if (take) begin
      cur <= after[15:8];
      if (pop)             rem <= rem + 4'd8 - need;
      else if (short_bits) rem <= '0;
      else                 rem <= rem - need;
    end
  end

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= 4'd8);

  // R9
  underrun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !pop);

endmodule

// File: rtl/subrate_xi_switch.sv
module subrate_xi_switch
  import subrate_pkg::*;
#(
  parameter int SLOTS      = 128,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  input  logic                     ser_in,
  output logic                     ser_out,
  input  logic                     cfg_we,
  input  logic [$clog2(SLOTS)-1:0] cfg_slot,
  input  logic [5:0]               cfg_word,
  input  logic                     ext_rd,
  output logic [7:0]               ext_data,
  output logic                     ext_valid,
  output logic                     ext_ovf,
  input  logic                     inj_we,
  input  logic [7:0]               inj_data,
  output logic                     inj_full,
  output logic                     inj_udr
);
  localparam int SW = $clog2(SLOTS);

  logic [SW-1:0] slot_idx;
  logic          slot_end;
  logic [5:0]    cfg_raw;
  slot_cfg_t     cfg;
  logic [7:0]    in_sr, slot_byte, out_sr, out_byte;
  logic          do_ext, do_inj, act_ok;
  logic [7:0]    acc;
  logic [3:0]    cnt;
  pack_t         pk;
  logic          ext_push, ext_empty, ext_full;
  logic [7:0]    inj_head;
  logic          inj_empty, inj_pop, inj_short;
  logic [1:0]    xbits, ibits;

  subrate_timing #(.SLOTS(SLOTS)) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .slot_idx(slot_idx), .slot_end(slot_end)
  );

  subrate_cmem #(.SLOTS(SLOTS), .CW(6)) u_cmem (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_slot), .wdata(cfg_word),
    .raddr(slot_idx), .rdata(cfg_raw)
  );

  assign cfg       = slot_cfg_t'(cfg_raw);
  assign slot_byte = {in_sr[6:0], ser_in};
  assign act_ok    = cfg_ok(cfg);
  assign do_ext    = slot_end && act_ok && cfg.mode[0];
  assign do_inj    = slot_end && act_ok && cfg.mode[1];
  assign xbits     = field_get(slot_byte, cfg);
  assign pk        = pack_step(acc, cnt, xbits, cfg.wide);
  assign ext_push  = do_ext && pk.done;

  subrate_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .take(do_inj), .two(cfg.wide),
    .head(inj_head), .head_valid(!inj_empty),
    .bits(ibits), .pop(inj_pop), .underrun(inj_short)
  );

  assign out_byte = do_inj ? field_put(slot_byte, cfg, ibits) : slot_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sr  <= '0;
      out_sr <= '0;
      acc    <= '0;
      cnt    <= '0;
    end else begin
      in_sr  <= slot_byte;
      out_sr <= slot_end ? out_byte : {out_sr[6:0], 1'b0};
      if (do_ext) begin
        acc <= pk.acc;
        cnt <= pk.cnt;
      end
    end
  end

  assign ser_out = out_sr[7];

  subrate_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_ext_fifo (
    .clk(clk), .rst_n(rst_n), .push(ext_push), .wdata(pk.data),
    .pop(ext_rd), .head(ext_data), .empty(ext_empty), .full(ext_full)
  );

  subrate_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_inj_fifo (
    .clk(clk), .rst_n(rst_n), .push(inj_we), .wdata(inj_data),
    .pop(inj_pop), .head(inj_head), .empty(inj_empty), .full(inj_full)
  );

  assign ext_valid = !ext_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_ovf <= 1'b0;
      inj_udr <= 1'b0;
    end else begin
      ext_ovf <= ext_ovf | (ext_push & ext_full);
      inj_udr <= inj_udr | inj_short;
    end
  end

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ovf |=> ext_ovf);

  // R9
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_udr |=> inj_udr);

  // R2
  ext_push_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_push |-> slot_end);

  // R4
  inj_pop_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pop |-> slot_end);

endmodule

// File: tb/subrate_xi_switch_tb.sv
module subrate_xi_switch_tb;
  localparam int NCYC   = 7 * 1024;
  localparam int RESYNC = 5 * 1024 + 303;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0, ser_in = 1'b0;
  logic       ser_out;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_slot = '0;
  logic [5:0] cfg_word = '0;
  logic       ext_rd = 1'b0;
  logic [7:0] ext_data;
  logic       ext_valid, ext_ovf;
  logic       inj_we = 1'b0;
  logic [7:0] inj_data = '0;
  logic       inj_full, inj_udr;

  subrate_xi_switch u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_in(ser_in),
    .ser_out(ser_out), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_word(cfg_word),
    .ext_rd(ext_rd), .ext_data(ext_data), .ext_valid(ext_valid), .ext_ovf(ext_ovf),
    .inj_we(inj_we), .inj_data(inj_data), .inj_full(inj_full), .inj_udr(inj_udr)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit         exp_bit [NCYC+16];
  string      exp_tag [NCYC+16];
  logic [5:0] mcfg [128];
  bit         xq [$];
  logic [7:0] ext_q [$];
  logic [7:0] inj_q [$];
  bit         ibq [$];
  bit         m_ovf = 0, m_udr = 0;
  logic [7:0] hist = '0;
  int         bpos = 0;
  bit         after_resync = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      if (n_bad <= 30)
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [5:0] directed_cfg(int s);
    case (s)
      1: return 6'b01_0_101;  // extract one bit at 5
      2: return 6'b01_1_011;  // extract bits 4,3
      3: return 6'b10_1_010;  // inject bits 3,2
      4: return 6'b10_0_111;  // inject bit 7
      5: return 6'b11_1_000;  // both at 1,0
      6: return 6'b11_1_111;  // invalid
      default: return 6'b00_0_000;
    endcase
  endfunction

  function automatic bit take_inj(ref bit udr);
    if (ibq.size() > 0) return ibq.pop_front();
    udr = 1;
    return 1'b1;
  endfunction

  // model one cycle after inputs are chosen
  task automatic model_cycle(input int k);
    int ext_sz0, inj_sz0, slot, p, n;
    bit wd, valid, got, udr_here;
    logic [1:0] md;
    logic [7:0] ob, nb;
    string tag;
    ext_sz0 = ext_q.size();
    inj_sz0 = inj_q.size();
    hist = {hist[6:0], ser_in};
    got = 0;
    if (bpos % 8 == 7) begin
      slot = bpos / 8;
      md = mcfg[slot][5:4]; wd = mcfg[slot][3]; p = int'(mcfg[slot][2:0]);
      valid = !(wd && p == 7);
      n = wd ? 2 : 1;
      ob = hist;
      udr_here = 0;
      if (md == 2'b00)      tag = "R1";
      else if (!valid)      tag = "R6";
      else if (md == 2'b11) tag = "R5";
      else if (md == 2'b10) tag = "R4";
      else                  tag = wd ? "R3" : "R2";
      if (valid && md[0]) begin
        if (wd) xq.push_back(hist[p+1]);
        xq.push_back(hist[p]);
        if (xq.size() >= 8) begin
          nb = '0;
          for (int i = 0; i < 8; i++) nb = {nb[6:0], xq.pop_front()};
          got = 1;
        end
      end
      if (valid && md[1]) begin
        if (ibq.size() < n && inj_sz0 > 0) begin
          logic [7:0] hb;
          hb = inj_q.pop_front();
          for (int i = 7; i >= 0; i--) ibq.push_back(hb[i]);
        end
        if (wd) ob[p+1] = take_inj(udr_here);
        ob[p] = take_inj(udr_here);
        if (udr_here) begin m_udr = 1; tag = "R9"; end
      end
      if (after_resync) begin tag = "R7"; after_resync = 0; end
      for (int j = 0; j < 8; j++) begin
        exp_bit[k+1+j] = ob[7-j];
        exp_tag[k+1+j] = tag;
      end
    end
    if (ext_rd && ext_sz0 > 0) void'(ext_q.pop_front());
    if (got) begin
      if (ext_sz0 < 16) ext_q.push_back(nb);
      else m_ovf = 1;
    end
    if (cfg_we) mcfg[cfg_slot] = cfg_word;
    if (inj_we && inj_sz0 < 16) inj_q.push_back(inj_data);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd5107);
    for (int i = 0; i < 128; i++) mcfg[i] = '0;
    for (int i = 0; i < NCYC + 16; i++) begin exp_bit[i] = 0; exp_tag[i] = "R1"; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ser_out == 1'b0, "R1", "reset ser_out", int'(ser_out), 0);
    chk(ext_valid == 1'b0, "R8", "reset ext_valid", int'(ext_valid), 0);
    chk(ext_ovf == 1'b0, "R8", "reset ext_ovf", int'(ext_ovf), 0);
    chk(inj_udr == 1'b0, "R9", "reset inj_udr", int'(inj_udr), 0);
    chk(inj_full == 1'b0, "R10", "reset inj_full", int'(inj_full), 0);
    for (int k = 0; k < NCYC; k++) begin
      if (k > 0) @(negedge clk);
      else rst_n = 1'b1;
      // compare outputs for cycle k
      chk(ser_out == exp_bit[k], exp_tag[k], "ser_out", int'(ser_out), int'(exp_bit[k]));
      chk(ext_valid == (ext_q.size() > 0), "R8", "ext_valid", int'(ext_valid), int'(ext_q.size() > 0));
      if (ext_q.size() > 0)
        chk(ext_data == ext_q[0], "R2", "ext_data", int'(ext_data), int'(ext_q[0]));
      chk(ext_ovf == m_ovf, "R8", "ext_ovf", int'(ext_ovf), int'(m_ovf));
      chk(inj_udr == m_udr, "R9", "inj_udr", int'(inj_udr), int'(m_udr));
      chk(inj_full == (inj_q.size() == 16), "R10", "inj_full", int'(inj_full), int'(inj_q.size() == 16));
      // stimulus for cycle k
      if (k == RESYNC) begin bpos = 0; after_resync = 1; end
      frame_sync = (bpos == 0);
      ser_in     = 1'($urandom);
      cfg_we     = 1'b0;
      if (k >= 16 && k < 144) begin
        cfg_we = 1'b1; cfg_slot = 7'(k - 16);
        if (k - 16 < 8 || k - 16 >= 120) cfg_word = directed_cfg(k - 16);
        else cfg_word = 6'($urandom);
      end else if (k >= 4200 && k < 4328) begin
        cfg_we = 1'b1; cfg_slot = 7'(k - 4200);
        cfg_word = (k - 4200 < 8) ? directed_cfg(k - 4200) : 6'($urandom);
      end
      inj_we   = ((k >= 200 && k <= 216) || (k >= 2048 && k < 4096 && k % 24 == 5));
      inj_data = 8'($urandom);
      ext_rd   = (k >= 3072) && ($urandom % 3 == 0);
      model_cycle(k);
      bpos = (bpos + 1) % 1024;
    end
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule